// File: doc/BRIEF.md
# Serially Programmed Three-Level Decision Tree

The block evaluates a small binary decision tree held entirely in registers. There are seven node slices: one root, two inner nodes and four bottom nodes. Every slice stores a mode bit and an 8-bit value. A regular slice compares an incoming feature against its stored weight. A leaf slice simply presents its stored value as a class label. Each inner node's comparison steers a multiplexer that picks the result of one of its two children, so the class label propagates up to the root.

Use has two phases, both driven over one serial input. A start strobe taken with the phase select high loads the model: the mode and weight bits of all seven slices form a single shift chain. A start strobe taken with the phase select low shifts the three feature values into the inner slices. One cycle after the last feature bit, a valid flag rises over the root result. The weights stay in place, so any number of feature sets can be classified against one programmed model.

Top module: `dtree_serial`

## Requirements
- R1: Reset clears every mode, weight and feature register and the valid flag. A tree that has not been programmed therefore reports label 0 from the root.
- R2: `startPulse` is accepted only while the controller is idle. On acceptance it samples `phaseSel` (1 = load model, 0 = load features), and the next 63 or 24 cycles each take one bit from `serialIn`.
- R3: The model stream visits the slices in this order: root, left inner, right inner, then the four bottom slices from left to right. Each slice receives 9 bits: first its mode bit (1 = regular compare node, 0 = leaf), then its 8-bit weight or label, most significant bit first.
- R4: The feature stream is 24 bits long: the root feature first, then the left inner feature, then the right inner feature, each MSB first. Loading features leaves the stored model untouched.
- R5: A regular node selects its right child when its feature is greater than or equal to its weight, and its left child otherwise. Equality therefore goes right.
- R6: An inner slice programmed as a leaf outputs its own stored label and ignores both of its subtrees. Bottom slices always output their stored label.
- R7: `resultValid` rises in the cycle after the last feature bit. It then stays high until the next accepted start, which clears it. It never rises after a model load.
- R8: A `startPulse` (with any `phaseSel`) arriving during a shift sequence has no effect. The sequence keeps its length, its phase and its bit assignment.
- R9: Loading a new feature set reclassifies against the stored model without reprogramming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Serial model or feature bit, one per shift cycle |
| phaseSel | input | 1 | Phase sampled with an accepted start: 1 model, 0 features |
| startPulse | input | 1 | Starts a shift sequence when idle |
| result | output | 8 | Class label at the root |
| resultValid | output | 1 | Root label is valid for the current features |

## Verification
The bench builds the block with its defaults: 8-bit slices and three levels. With these values the four root-to-leaf paths and the pruned shapes can all be enumerated. Feature values can be placed at a weight, one below it, and at 0 and 255 to probe the greater-or-equal boundary. Random models and feature sets from a fixed seed are checked against a bench-side tree walk. Directed runs inject a start strobe with a flipped phase in the middle of each kind of sequence.

// File: rtl/dtree_pkg.sv
package dtree_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic progShift;
    logic featShift;
  } shiftCtl_t;
endpackage

// File: rtl/dtree_slice.sv
// One tree node: mode bit on top of a weight/label, shifted as one link of the model chain.
module dtree_slice #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              bitIn,
  output logic              bitOut,
  output logic [DATA_W-1:0] weight
);
  logic [DATA_W:0] cfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfg <= '0;
    else if (shiftEn) cfg <= {cfg[DATA_W-1:0], bitIn};
  end

  // top bit is the mode and also feeds the next slice toward the root
  assign bitOut = cfg[DATA_W];
  assign weight = cfg[DATA_W-1:0];
endmodule

// File: rtl/dtree_ctrl.sv
module dtree_ctrl
  import dtree_pkg::*;
#(
  parameter int PROG_LEN = 63,
  parameter int FEAT_LEN = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      phaseSel,
  input  logic      startPulse,
  output shiftCtl_t ctl,
  output logic      resultValid
);
  localparam int CNT_W = $clog2(PROG_LEN + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_LEN - 1);
  localparam logic [CNT_W-1:0] FEAT_LAST = CNT_W'(FEAT_LEN - 1);

  logic             busy;
  logic             isProg;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit = isProg ? (bitCnt == PROG_LAST) : (bitCnt == FEAT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      isProg      <= 1'b0;
      bitCnt      <= '0;
      resultValid <= 1'b0;
    end else if (!busy) begin
      if (startPulse) begin
        busy        <= 1'b1;
        isProg      <= phaseSel;
        bitCnt      <= '0;
        resultValid <= 1'b0;
      end
    end else begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) begin
        busy        <= 1'b0;
        resultValid <= !isProg;
      end
    end
  end

  assign ctl.progShift = busy && isProg;
  assign ctl.featShift = busy && !isProg;

  assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.progShift, ctl.featShift}));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= (isProg ? PROG_LAST : FEAT_LAST)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBit) |=> (busy && $stable(isProg)));

  assert_valid_after_feat_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(ctl.featShift));

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !startPulse) |=> resultValid);
endmodule

// File: rtl/dtree_path.sv
module dtree_path
  import dtree_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEVELS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  shiftCtl_t         ctl,
  output logic [DATA_W-1:0] rootVal
);
  localparam int NODES = (1 << LEVELS) - 1;
  localparam int INNER = (1 << (LEVELS - 1)) - 1;

  logic [NODES-1:0]             chainBit;   // slice top bit = its mode
  logic [NODES-1:0][DATA_W-1:0] weightArr;
  logic [INNER-1:0][DATA_W-1:0] featArr;

  for (genvar s = 0; s < NODES; s++) begin : g_slice
    logic linkIn;
    if (s == NODES - 1) begin : g_tail
      assign linkIn = serialIn;
    end else begin : g_link
      assign linkIn = chainBit[s+1];
    end
    dtree_slice #(.DATA_W(DATA_W)) u_slice (
      .clk    (clk),
      .rstN   (rstN),
      .shiftEn(ctl.progShift),
      .bitIn  (linkIn),
      .bitOut (chainBit[s]),
      .weight (weightArr[s])
    );
  end

  for (genvar f = 0; f < INNER; f++) begin : g_feat
    logic featIn;
    if (f == INNER - 1) begin : g_tail
      assign featIn = serialIn;
    end else begin : g_link
      assign featIn = featArr[f+1][DATA_W-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              featArr[f] <= '0;
      else if (ctl.featShift) featArr[f] <= {featArr[f][DATA_W-2:0], featIn};
    end
  end

  // bottom-up select: a regular node passes its right child when feature >= weight
  always_comb begin
    logic [NODES-1:0][DATA_W-1:0] nodeVal;
    for (int i = NODES - 1; i >= INNER; i--) nodeVal[i] = weightArr[i];
    for (int i = INNER - 1; i >= 0; i--) begin
      if (!chainBit[i])                     nodeVal[i] = weightArr[i];
      else if (featArr[i] >= weightArr[i])  nodeVal[i] = nodeVal[2*i+2];
      else                                  nodeVal[i] = nodeVal[2*i+1];
    end
    rootVal = nodeVal[0];
  end

  assert_model_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.progShift |=> ($stable(weightArr) && $stable(chainBit)));

  assert_feat_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.featShift |=> $stable(featArr));

  assert_leaf_root_R6: assert property (@(posedge clk) disable iff (!rstN)
    !chainBit[0] |-> (rootVal == weightArr[0]));
endmodule

// File: rtl/dtree_serial.sv
module dtree_serial
  import dtree_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEVELS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              phaseSel,
  input  logic              startPulse,
  output logic [DATA_W-1:0] result,
  output logic              resultValid
);
  localparam int NODES    = (1 << LEVELS) - 1;
  localparam int INNER    = (1 << (LEVELS - 1)) - 1;
  localparam int PROG_LEN = NODES * (DATA_W + 1);
  localparam int FEAT_LEN = INNER * DATA_W;

  shiftCtl_t ctl;

  dtree_ctrl #(.PROG_LEN(PROG_LEN), .FEAT_LEN(FEAT_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseSel   (phaseSel),
    .startPulse (startPulse),
    .ctl        (ctl),
    .resultValid(resultValid)
  );

  dtree_path #(.DATA_W(DATA_W), .LEVELS(LEVELS)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .serialIn(serialIn),
    .ctl     (ctl),
    .rootVal (result)
  );
endmodule

// File: tb/dtree_serial_bench.sv
`timescale 1ns/1ps
module dtree_serial_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b0;
  logic       phaseSel = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] result;
  logic       resultValid;

  int testsRun = 0;
  int testsFailed = 0;

  logic       mMode [0:6];
  logic [7:0] mW    [0:6];
  logic [7:0] mF    [0:2];
  logic       stream [0:62];

  always #2 clk = ~clk;

  dtree_serial u_dtree_serial (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .phaseSel(phaseSel),
    .startPulse(startPulse), .result(result), .resultValid(resultValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] walk();
    int idx = 0;
    while (idx < 3 && mMode[idx]) idx = (mF[idx] >= mW[idx]) ? 2*idx + 2 : 2*idx + 1;
    return mW[idx];
  endfunction

  // drive one sequence; glitchAt >= 0 pulses start with a flipped phase mid-stream
  task automatic runSeq(input logic ph, input int len, input int glitchAt, input string req);
    @(negedge clk); startPulse = 1'b1; phaseSel = ph;
    @(negedge clk); startPulse = 1'b0;
    for (int k = 0; k < len; k++) begin
      serialIn   = stream[k];
      startPulse = (k == glitchAt);
      phaseSel   = (k == glitchAt) ? ~ph : ph;
      if (k == len - 1) check(resultValid == 1'b0, req, resultValid, 0);
      @(negedge clk);
    end
    startPulse = 1'b0; phaseSel = ph; serialIn = 1'b0;
  endtask

  task automatic programModel(input int glitchAt);
    for (int s = 0; s < 7; s++) begin
      stream[s*9] = mMode[s];
      for (int b = 0; b < 8; b++) stream[s*9 + 1 + b] = mW[s][7-b];
    end
    runSeq(1'b1, 63, glitchAt, "R3");
    check(resultValid == 1'b0, "R7 no valid after model load", resultValid, 0);
  endtask

  task automatic classify(input int glitchAt, input string req);
    for (int n = 0; n < 3; n++)
      for (int b = 0; b < 8; b++) stream[n*8 + b] = mF[n][7-b];
    runSeq(1'b0, 24, glitchAt, "R7 valid low during load");
    check(resultValid == 1'b1, "R7 valid after last bit", resultValid, 1);
    check(result == walk(), req, result, walk());
  endtask

  task automatic randModel();
    for (int s = 0; s < 7; s++) begin
      mMode[s] = ($urandom_range(0, 3) != 0);
      mW[s]    = 8'($urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(result == 8'd0 && resultValid == 1'b0, "R1 reset outputs", result, 0);
    rstN = 1'b1;
    // unprogrammed tree: every slice is a leaf holding 0
    for (int s = 0; s < 7; s++) begin mMode[s] = 1'b0; mW[s] = 8'd0; end
    mF[0] = 8'hA5; mF[1] = 8'h3C; mF[2] = 8'hFF;
    classify(-1, "R1 cleared model gives 0");

    // full tree: root 100, left 50, right 200, leaves 11,22,33,44
    mMode = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    mW    = '{8'd100, 8'd50, 8'd200, 8'd11, 8'd22, 8'd33, 8'd44};
    programModel(-1);
    check(resultValid == 1'b0, "R7 model load clears valid", resultValid, 0);
    mF = '{8'd99, 8'd49, 8'd0};   classify(-1, "R5 left-left path");
    check(result == 8'd11, "R3 slice order leaf0", result, 11);
    mF = '{8'd99, 8'd50, 8'd0};   classify(-1, "R5 equal goes right");
    check(result == 8'd22, "R5 equal left node", result, 22);
    mF = '{8'd100, 8'd0, 8'd199}; classify(-1, "R5 root equal right-left");
    check(result == 8'd33, "R4 feature order", result, 33);
    mF = '{8'd255, 8'd0, 8'd200}; classify(-1, "R9 reclassify right-right");
    check(result == 8'd44, "R9 reclassify value", result, 44);
    repeat (5) @(negedge clk);
    check(resultValid == 1'b1 && result == 8'd44, "R7 valid held", resultValid, 1);

    // pruned shapes: left inner is a leaf
    mMode[1] = 1'b0; mW[1] = 8'd77;
    programModel(-1);
    mF = '{8'd0, 8'd255, 8'd255}; classify(-1, "R6 inner leaf overrides subtree");
    check(result == 8'd77, "R6 pruned label", result, 77);
    mMode[0] = 1'b0; mW[0] = 8'd5;
    programModel(-1);
    mF = '{8'd255, 8'd255, 8'd255}; classify(-1, "R6 root leaf");

    // start strobes injected mid-stream
    mMode = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    mW    = '{8'd0, 8'd255, 8'd128, 8'd1, 8'd2, 8'd3, 8'd4};
    programModel(30);
    mF = '{8'd0, 8'd254, 8'd0};   classify(-1, "R8 model intact after stray start");
    mF = '{8'd0, 8'd255, 8'd128}; classify(10, "R8 feature load intact after stray start");

    // random models and features
    for (int m = 0; m < 10; m++) begin
      randModel();
      programModel(-1);
      for (int t = 0; t < 20; t++) begin
        for (int n = 0; n < 3; n++) begin
          case ($urandom_range(0, 3))
            0: mF[n] = mW[n];
            1: mF[n] = mW[n] - 8'd1;
            default: mF[n] = 8'($urandom);
          endcase
        end
        classify(-1, "R5 random tree walk");
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule